// File: doc/BRIEF.md
# Power-Mode and Clock-Enable Controller

This block decides which clock enables of a small microcontroller-style system are active. In normal operation the processor enable is high and a peripheral tick is produced by dividing the processor clock by 1, 2 or 4. Each peripheral's enable is that tick gated by its own bit in a power mask. Software writes a mode register to put the system into one of two sleep depths. In Idle only the processor enable stops. In Power-down every enable stops and the oscillator request is dropped.

Idle ends on any ordinary interrupt or on the asynchronous wake request. Power-down ends only on the asynchronous wake request, which passes through a two-stage synchronizer. A wake from Power-down clears the mode to run at once and raises the oscillator request again. The processor and peripheral enables then stay low for a stabilization count. A wake-cause register records what ended the last sleep. The oscillator, the PLL and the real-time clock are outside the block and are driven only through request outputs.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: Mode codes are 00 run, 01 Idle, 10 Power-down, and reset selects run. A write of 11 leaves the system in run. Writes are accepted only while in run with the processor enable high. `mode_stat` shows the mode register.
- R2: In Idle `cpu_clk_en` is 0, `osc_en` is 1 and the peripheral tick keeps its programmed spacing.
- R3: In Idle a high `irq` sampled at a clock edge returns the mode to run at that edge, with `cpu_clk_en` high from then on.
- R4: In Power-down `osc_en`, `cpu_clk_en`, `pclk_en` and all `periph_clk_en` bits are 0. `irq` does not end Power-down.
- R5: `periph_clk_en[i]` equals `pclk_en` AND mask bit i, in every mode. Mask bit 1 means powered. Reset sets the mask to all ones.
- R6: Divider code 01 gives a tick every cycle, 10 every 2 cycles, and 00 or 11 every 4 cycles. Reset selects 00.
- R7: A new divider code takes effect only at a terminal count, so the spacing of every interval after the next tick matches the new code.
- R8: In Power-down `rtc_en` follows `rtc_ext_sel` (1 = external slow clock keeps the RTC running). Outside Power-down `rtc_en` is 1.
- R9: `pll_en` is 0 in Power-down. In Idle it keeps the value `pll_req` had at Idle entry. Otherwise it follows `pll_req`.
- R10: At each wake `wake_cause` is loaded with bit1 = asynchronous wake and bit0 = interrupt, both as seen at the wake edge. Reset sets it to 00.
- R11: After a Power-down wake the mode reads run and `osc_en` is 1 at once. `cpu_clk_en` and `pclk_en` stay 0 for STABLE_CYC cycles (default 16).
- R12: `wake_async` acts at the third clock edge after it rises, because of its two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Mode code to write |
| ratio_wr | input | 1 | Divider code write strobe |
| ratio_wdata | input | 2 | Divider code to write |
| mask_wr | input | 1 | Power mask write strobe |
| mask_wdata | input | NPERIPH | Power mask value, 1 = powered |
| irq | input | 1 | Any enabled ordinary interrupt |
| wake_async | input | 1 | Clockless wake request |
| pll_req | input | 1 | Software PLL enable request |
| rtc_ext_sel | input | 1 | RTC source is the external slow clock |
| cpu_clk_en | output | 1 | Processor clock enable |
| pclk_en | output | 1 | Divided peripheral tick |
| periph_clk_en | output | NPERIPH | Per-peripheral clock enables |
| osc_en | output | 1 | Oscillator enable request |
| pll_en | output | 1 | PLL enable request |
| rtc_en | output | 1 | RTC enable |
| mode_stat | output | 2 | Current mode code |
| wake_cause | output | 2 | Cause of the last wake |

## Verification
Both wake sources can land on the same Idle wake edge: a synchronized `wake_async` and an `irq`. The bench raises `wake_async`, waits two edges for it to pass through the synchronizer, and then raises `irq` so that both are sampled at the third edge. The result must be a single return to run with `wake_cause` equal to 11. A divider-code write can also fall on the edge where a terminal count occurs. Random code changes hit that case, and the bench checks that the interval after the next tick already matches the new code.

// File: rtl/pwr_pkg.sv
// Shared types for the power-mode controller.
// Assumes: 2-bit mode and divider codes as listed in the brief.
package pwr_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_IDLE  = 2'b01,
        MODE_PDOWN = 2'b10
    } pmode_t;

    localparam logic [1:0] DIV_QUARTER = 2'b00;
    localparam logic [1:0] DIV_FULL    = 2'b01;
    localparam logic [1:0] DIV_HALF    = 2'b10;

    // Terminal count value of the divider for a given code.
    function automatic logic [1:0] div_last(input logic [1:0] code);
        case (code)
            DIV_FULL: div_last = 2'd0;
            DIV_HALF: div_last = 2'd1;
            default:  div_last = 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/pwr_mode_ctrl.sv
// Mode register, wake detection, wake cause, post-power-down stabilization
// counter and PLL request hold.
// Assumes: clk is always running; wake_async may change at any time.
module pwr_mode_ctrl
    import pwr_pkg::*;
#(
    parameter int unsigned STABLE_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [1:0] mode_wdata,
    input  logic       irq,
    input  logic       wake_async,
    input  logic       pll_req,
    output pmode_t     mode_q,
    output logic       stabilizing,
    output logic [1:0] wake_cause,
    output logic       pll_en
);

    localparam int unsigned SW = $clog2(STABLE_CYC + 1);

    logic          wk_s1, wk_s2;
    logic [SW-1:0] stab_cnt;
    logic          pll_hold;
    logic          wake_idle, wake_pd, accept_wr;

    assign stabilizing = (stab_cnt != '0);
    assign wake_idle   = (mode_q == MODE_IDLE) && (irq || wk_s2);
    assign wake_pd     = (mode_q == MODE_PDOWN) && wk_s2;
    assign accept_wr   = mode_wr && (mode_q == MODE_RUN) && !stabilizing;

    // Two-stage synchronizer for the clockless wake request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wk_s1 <= 1'b0;
            wk_s2 <= 1'b0;
        end else begin
            wk_s1 <= wake_async;
            wk_s2 <= wk_s1;
        end
    end

    // Mode register: software entry, self-clear to run on wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RUN;
        end else if (wake_idle || wake_pd) begin
            mode_q <= MODE_RUN;
        end else if (accept_wr) begin
            mode_q <= (mode_wdata == 2'b11) ? MODE_RUN : pmode_t'(mode_wdata);
        end
    end

    // Wake cause: bit1 asynchronous request, bit0 ordinary interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_cause <= 2'b00;
        end else if (wake_idle || wake_pd) begin
            wake_cause <= {wk_s2, irq && (mode_q == MODE_IDLE)};
        end
    end

    // Oscillator stabilization count after leaving power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stab_cnt <= '0;
        end else if (wake_pd) begin
            stab_cnt <= SW'(STABLE_CYC);
        end else if (stabilizing) begin
            stab_cnt <= stab_cnt - 1'b1;
        end
    end

    // Capture the PLL request on Idle entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pll_hold <= 1'b0;
        end else if (accept_wr && (mode_wdata == MODE_IDLE)) begin
            pll_hold <= pll_req;
        end
    end

    always_comb begin
        case (mode_q)
            MODE_PDOWN: pll_en = 1'b0;
            MODE_IDLE:  pll_en = pll_hold;
            default:    pll_en = pll_req;
        endcase
    end

    AST_IDLE_IRQ_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_IDLE && irq) |=> (mode_q == MODE_RUN)); // R3
    AST_PD_IGNORES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PDOWN && !wk_s2) |=> (mode_q == MODE_PDOWN)); // R4
    AST_PD_WAKE_STABILIZES: assert property (@(posedge clk) disable iff (!rst_n)
        (STABLE_CYC > 0 && $past(mode_q) == MODE_PDOWN && mode_q == MODE_RUN) |-> stabilizing); // R11
    AST_PLL_OFF_PD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PDOWN) |-> !pll_en); // R9

endmodule

// File: rtl/pwr_pclk_div.sv
// Peripheral tick divider. Advances only while clocks run. A written code is
// staged and applied at the next terminal count to avoid a short interval.
// Assumes: run_en is low in power-down and during stabilization.
module pwr_pclk_div
    import pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       ratio_wr,
    input  logic [1:0] ratio_wdata,
    output logic       tick
);

    logic [1:0] cnt, ratio_act, ratio_pend, pend_next;

    assign pend_next = ratio_wr ? ratio_wdata : ratio_pend;
    assign tick      = run_en && (cnt == div_last(ratio_act));

    // Staged divider code; reset selects the slowest ratio.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_pend <= DIV_QUARTER;
        end else begin
            ratio_pend <= pend_next;
        end
    end

    // Counter and active code, swapped only at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= 2'd0;
            ratio_act <= DIV_QUARTER;
        end else if (tick) begin
            cnt       <= 2'd0;
            ratio_act <= pend_next;
        end else if (run_en) begin
            cnt <= cnt + 2'd1;
        end
    end

    AST_RATIO_AT_TC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ratio_act) |-> $past(tick)); // R7
    AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !tick); // R4

endmodule

// File: rtl/pwr_gate.sv
// Clock-enable gating from mode, stabilization state and power mask.
// Assumes: tick is already zero when clocks are frozen.
module pwr_gate
    import pwr_pkg::*;
#(
    parameter int unsigned NPERIPH = 4
) (
    input  pmode_t             mode_q,
    input  logic               stabilizing,
    input  logic               tick,
    input  logic [NPERIPH-1:0] periph_on,
    input  logic               rtc_ext_sel,
    output logic               clocks_run,
    output logic               cpu_clk_en,
    output logic               pclk_en,
    output logic [NPERIPH-1:0] periph_clk_en,
    output logic               osc_en,
    output logic               rtc_en
);

    assign clocks_run = (mode_q != MODE_PDOWN) && !stabilizing;
    assign cpu_clk_en = (mode_q == MODE_RUN) && !stabilizing;
    assign pclk_en    = clocks_run && tick;
    assign osc_en     = (mode_q != MODE_PDOWN);
    assign rtc_en     = (mode_q != MODE_PDOWN) || rtc_ext_sel;

    // One enable per peripheral, each gated by its own mask bit.
    for (genvar i = 0; i < NPERIPH; i++) begin : g_periph
        assign periph_clk_en[i] = pclk_en && periph_on[i];
    end

endmodule

// File: rtl/pwr_clk_ctrl.sv
// Top of the power-mode and clock-enable controller: holds the power mask
// and joins the mode controller, divider and gating.
// Assumes: register writes come as single-cycle strobes.
module pwr_clk_ctrl
    import pwr_pkg::*;
#(
    parameter int unsigned NPERIPH    = 4,
    parameter int unsigned STABLE_CYC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_wr,
    input  logic [1:0]         mode_wdata,
    input  logic               ratio_wr,
    input  logic [1:0]         ratio_wdata,
    input  logic               mask_wr,
    input  logic [NPERIPH-1:0] mask_wdata,
    input  logic               irq,
    input  logic               wake_async,
    input  logic               pll_req,
    input  logic               rtc_ext_sel,
    output logic               cpu_clk_en,
    output logic               pclk_en,
    output logic [NPERIPH-1:0] periph_clk_en,
    output logic               osc_en,
    output logic               pll_en,
    output logic               rtc_en,
    output logic [1:0]         mode_stat,
    output logic [1:0]         wake_cause
);

    pmode_t             mode_q;
    logic               stabilizing, clocks_run, tick;
    logic [NPERIPH-1:0] periph_on;

    // Power mask register, all peripherals powered after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            periph_on <= '1;
        end else if (mask_wr) begin
            periph_on <= mask_wdata;
        end
    end

    assign mode_stat = mode_q;

    pwr_mode_ctrl #(.STABLE_CYC(STABLE_CYC)) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wr     (mode_wr),
        .mode_wdata  (mode_wdata),
        .irq         (irq),
        .wake_async  (wake_async),
        .pll_req     (pll_req),
        .mode_q      (mode_q),
        .stabilizing (stabilizing),
        .wake_cause  (wake_cause),
        .pll_en      (pll_en)
    );

    pwr_pclk_div u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (clocks_run),
        .ratio_wr    (ratio_wr),
        .ratio_wdata (ratio_wdata),
        .tick        (tick)
    );

    pwr_gate #(.NPERIPH(NPERIPH)) u_gate (
        .mode_q        (mode_q),
        .stabilizing   (stabilizing),
        .tick          (tick),
        .periph_on     (periph_on),
        .rtc_ext_sel   (rtc_ext_sel),
        .clocks_run    (clocks_run),
        .cpu_clk_en    (cpu_clk_en),
        .pclk_en       (pclk_en),
        .periph_clk_en (periph_clk_en),
        .osc_en        (osc_en),
        .rtc_en        (rtc_en)
    );

    AST_PD_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PDOWN) |-> (!cpu_clk_en && !osc_en && !pclk_en && periph_clk_en == '0)); // R4
    AST_IDLE_CPU_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_IDLE) |-> (!cpu_clk_en && osc_en)); // R2
    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_clk_en & ~periph_on) == '0); // R5
    AST_RTC_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PDOWN) |-> (rtc_en == rtc_ext_sel)); // R8

endmodule

// File: tb/pwr_clk_ctrl_test.sv
module pwr_clk_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 4;
    localparam int STAB       = 16;

    logic          clk = 1'b0;
    logic          rst_n, mode_wr, ratio_wr, mask_wr, irq, wake_async, pll_req, rtc_ext_sel;
    logic [1:0]    mode_wdata, ratio_wdata;
    logic [NP-1:0] mask_wdata;
    logic          cpu_clk_en, pclk_en, osc_en, pll_en, rtc_en;
    logic [NP-1:0] periph_clk_en;
    logic [1:0]    mode_stat, wake_cause;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwr_clk_ctrl #(.NPERIPH(NP), .STABLE_CYC(STAB)) uut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .ratio_wr(ratio_wr), .ratio_wdata(ratio_wdata), .mask_wr(mask_wr),
        .mask_wdata(mask_wdata), .irq(irq), .wake_async(wake_async),
        .pll_req(pll_req), .rtc_ext_sel(rtc_ext_sel), .cpu_clk_en(cpu_clk_en),
        .pclk_en(pclk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
        .pll_en(pll_en), .rtc_en(rtc_en), .mode_stat(mode_stat), .wake_cause(wake_cause)
    );

    function automatic int exp_gap(input logic [1:0] code);
        case (code)
            2'b01:   return 1;
            2'b10:   return 2;
            default: return 4;
        endcase
    endfunction

    function automatic int exp_periph(input logic tick, input logic [NP-1:0] m);
        return tick ? int'(m) : 0;
    endfunction

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_mode(input logic [1:0] v);
        mode_wr = 1'b1; mode_wdata = v;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic wr_ratio(input logic [1:0] v);
        ratio_wr = 1'b1; ratio_wdata = v;
        @(negedge clk);
        ratio_wr = 1'b0;
    endtask

    task automatic wr_mask(input logic [NP-1:0] v);
        mask_wr = 1'b1; mask_wdata = v;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    // Wait for a tick, then count cycles to the following tick.
    task automatic measure_gap(output int gap);
        int guard = 0;
        @(negedge clk);
        while (!pclk_en && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!pclk_en && gap < 50);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int gap, cnt, seed;
        logic [1:0]    code;
        logic [NP-1:0] m;
        seed = $urandom(32'd4242);
        rst_n = 1'b0; mode_wr = 0; ratio_wr = 0; mask_wr = 0; irq = 0;
        wake_async = 0; pll_req = 0; rtc_ext_sel = 0;
        mode_wdata = 0; ratio_wdata = 0; mask_wdata = 0;
        step(4);
        rst_n = 1'b1;
        step(1);

        // Reset state
        check_eq("R1", "reset mode", int'(mode_stat), 0);
        check_eq("R1", "reset cpu_clk_en", int'(cpu_clk_en), 1);
        check_eq("R2", "reset osc_en", int'(osc_en), 1);
        check_eq("R10", "reset wake_cause", int'(wake_cause), 0);
        measure_gap(gap);
        check_eq("R6", "reset divider gap", gap, 4);
        check_eq("R5", "reset mask all on", int'(periph_clk_en), exp_periph(pclk_en, '1));

        // Reserved mode code
        wr_mode(2'b11);
        check_eq("R1", "mode after 11 write", int'(mode_stat), 0);

        // Random divider codes, including writes that meet a terminal count
        for (int k = 0; k < 10; k++) begin
            code = 2'($urandom % 4);
            step($urandom % 4);
            wr_ratio(code);
            measure_gap(gap);
            check_eq("R7", "first interval after code change", gap, exp_gap(code));
            measure_gap(gap);
            check_eq("R6", "steady interval", gap, exp_gap(code));
        end

        // Random power masks
        wr_ratio(2'b10);
        for (int k = 0; k < 12; k++) begin
            m = NP'($urandom);
            wr_mask(m);
            for (int j = 0; j < 5; j++) begin
                check_eq("R5", "periph enables", int'(periph_clk_en), exp_periph(pclk_en, m));
                step(1);
            end
        end
        m = 4'b1011;
        wr_mask(m);

        // Idle entry with PLL requested, then irq wake
        pll_req = 1'b1;
        wr_mode(2'b01);
        pll_req = 1'b0;
        step(1);
        check_eq("R1", "mode idle", int'(mode_stat), 1);
        check_eq("R2", "idle cpu_clk_en", int'(cpu_clk_en), 0);
        check_eq("R2", "idle osc_en", int'(osc_en), 1);
        check_eq("R9", "idle pll hold high", int'(pll_en), 1);
        check_eq("R8", "idle rtc_en", int'(rtc_en), 1);
        measure_gap(gap);
        check_eq("R2", "idle tick interval", gap, 2);
        check_eq("R5", "idle periph enables", int'(periph_clk_en), exp_periph(pclk_en, m));
        irq = 1'b1;
        step(1);
        irq = 1'b0;
        check_eq("R3", "irq wake mode", int'(mode_stat), 0);
        check_eq("R3", "irq wake cpu", int'(cpu_clk_en), 1);
        check_eq("R10", "irq wake cause", int'(wake_cause), 1);
        check_eq("R9", "pll after idle", int'(pll_en), 0);

        // Idle entry without PLL, both wake sources on the same edge
        wr_mode(2'b01);
        pll_req = 1'b1;
        step(1);
        check_eq("R9", "idle pll hold low", int'(pll_en), 0);
        wake_async = 1'b1;
        step(2);
        check_eq("R12", "still idle before sync", int'(mode_stat), 1);
        irq = 1'b1;
        step(1);
        irq = 1'b0; wake_async = 1'b0;
        check_eq("R3", "joint wake mode", int'(mode_stat), 0);
        check_eq("R10", "joint wake cause", int'(wake_cause), 3);
        step(3);

        // Idle wake by asynchronous request only
        wr_mode(2'b01);
        wake_async = 1'b1;
        step(2);
        check_eq("R12", "idle before third edge", int'(mode_stat), 1);
        step(1);
        wake_async = 1'b0;
        check_eq("R12", "async wake from idle", int'(mode_stat), 0);
        check_eq("R10", "async wake cause", int'(wake_cause), 2);
        step(3);

        // Power-down with external RTC source, several random rounds
        for (int r = 0; r < 3; r++) begin
            rtc_ext_sel = (r != 1);
            wr_mode(2'b10);
            for (int j = 0; j < 4; j++) begin
                irq = 1'($urandom);
                step(1);
                check_eq("R4", "pd mode kept", int'(mode_stat), 2);
                check_eq("R4", "pd osc_en", int'(osc_en), 0);
                check_eq("R4", "pd cpu/pclk", int'({cpu_clk_en, pclk_en}), 0);
                check_eq("R4", "pd periph", int'(periph_clk_en), 0);
                check_eq("R8", "pd rtc_en", int'(rtc_en), int'(rtc_ext_sel));
                check_eq("R9", "pd pll_en", int'(pll_en), 0);
            end
            irq = 1'b1;
            step(3);
            irq = 1'b0;
            check_eq("R4", "irq ignored in pd", int'(mode_stat), 2);
            wake_async = 1'b1;
            step(2);
            check_eq("R12", "pd before third edge", int'(mode_stat), 2);
            step(1);
            wake_async = 1'b0;
            check_eq("R11", "pd wake mode", int'(mode_stat), 0);
            check_eq("R11", "pd wake osc_en", int'(osc_en), 1);
            check_eq("R11", "pd wake pclk held", int'(pclk_en), 0);
            check_eq("R10", "pd wake cause", int'(wake_cause), 2);
            cnt = 0;
            while (!cpu_clk_en && cnt < 100) begin
                if (pclk_en) check_eq("R11", "tick during stabilization", 1, 0);
                cnt++;
                step(1);
            end
            check_eq("R11", "stabilization length", cnt, STAB);
            measure_gap(gap);
            check_eq("R6", "interval after pd", gap, 2);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule